// File: doc/BRIEF.md
# Pixel Clock Speed Switcher

This block sits beside a display controller and a two-speed clock enhancer. It starts a new evaluation when a display mode-change strobe or a system-reset strobe arrives. On that strobe it captures the requested video clock frequency, given in kHz. A request of 30000 kHz or more selects the high rate. Anything lower selects the low rate, so a 25175 kHz request falls back to the low rate.

The speed choice is a single select bit, at position 5 of an 8-bit output latch that other agents share. The block keeps a shadow copy of that latch. It reads the shadow, clears the select bit, ORs in the new value and stores the result back into the shadow. It then writes the whole byte to the hardware latch, with a write strobe. A configuration input inverts the meaning of the select bit, for enhancer boards whose control line is active low.

Other writers reach the latch through a lock handshake. While they hold the grant, they write the bits they own through this block, and the shadow stays coherent. While an update is in progress, the grant is withheld. While the grant is held, updates are deferred.

Top module: `pixclk_switch`

## Requirements
- R1: While reset is asserted, the latch output reads 0x00, the write strobe is low and the grant is low. On the first cycle after reset is released, the block emits exactly one write strobe carrying 0x00.
- R2: When the block is idle and no grant is held, a mode-change strobe or a reset strobe causes the following. Busy is high for exactly two cycles, starting the cycle after the strobe. The write strobe is high on the cycle busy returns low.
- R3: With the invert input at 0, the written latch bit 5 is 1 when the captured frequency is at least 30000 kHz. Otherwise it is 0. For example, 29999 and 25175 give 0, while 30000 and 36000 give 1.
- R4: With the invert input at 1, the value written to bit 5 is the complement of the R3 value.
- R5: A speed update leaves every latch bit other than bit 5 at its previous value.
- R6: While the grant is high, a write enable with data D loads D into every latch bit except bit 5. Bit 5 keeps its value. The result appears on the latch output with a one-cycle write strobe, on the cycle after the write.
- R7: The grant rises only when the block is idle, has no pending event and sees no strobe in the same cycle. The grant stays high while the request stays high. The grant and busy are never high together.
- R8: A strobe that arrives while the grant is high leaves the latch untouched and busy low. The update then runs after the request is dropped: busy rises two cycles after the drop, and the write follows two cycles later.
- R9: The latch output changes only on a cycle where the write strobe is high.
- R10: A write enable while the grant is low is ignored. The latch does not change and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_evt_i | input | 1 | Display mode-change strobe, one cycle |
| reset_evt_i | input | 1 | System reset-event strobe, one cycle |
| freq_khz_i | input | FREQ_W | Requested video clock in kHz, sampled with a strobe |
| invert_i | input | 1 | 1 inverts the polarity of the speed select bit |
| lock_req_i | input | 1 | Other writer requests exclusive latch access |
| lock_grant_o | output | 1 | Exclusive access granted to the other writer |
| wr_en_i | input | 1 | Other writer's latch write enable, honoured only while granted |
| wr_data_i | input | LATCH_W | Other writer's latch byte; bit 5 is ignored |
| busy_o | output | 1 | Update in progress |
| latch_o | output | LATCH_W | Hardware latch byte |
| latch_we_o | output | 1 | One-cycle latch write strobe |

## Verification
The checker watches the lock on every cycle. It checks that the grant and busy are never high together, that an idle strobe starts an update on the next cycle, and that every fall of busy coincides with a latch write. It also checks that the latch never moves without a strobe and that a granted write cannot alter the select bit. The bench scenarios cover the rest. These are the frequency threshold on both sides of 30000 kHz, with and without inversion, and the preservation of the other latch bits across updates. They also cover the exact deferral timing after the lock is released, the refusal of ungranted writes, and the single write after reset.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

    localparam int DEF_LATCH_W    = 8;
    localparam int DEF_SEL_BIT    = 5;
    localparam int DEF_FREQ_W     = 16;
    localparam int DEF_THRESH_KHZ = 30000;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_MODIFY,
        ST_WRITE
    } seq_state_t;

    typedef struct packed {
        logic modify;
        logic commit;
    } rmw_ctl_t;

    function automatic logic speed_select(
        input logic [31:0] freq,
        input logic [31:0] thresh,
        input logic        invert
    );
        return (freq >= thresh) ^ invert;
    endfunction

endpackage

// File: rtl/pixclk_seq.sv
module pixclk_seq
    import pixclk_pkg::*;
#(
    parameter int FREQ_W = DEF_FREQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              lock_req_i,
    output logic [FREQ_W-1:0] freq_q_o,
    output logic              lock_grant_o,
    output logic              busy_o,
    output rmw_ctl_t          ctl_o
);

    seq_state_t        state_q;
    logic              pend_q;
    logic              grant_q;
    logic [FREQ_W-1:0] freq_q;
    logic              start;

    assign start = (evt_i || pend_q) && !grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            pend_q  <= 1'b0;
            grant_q <= 1'b0;
            freq_q  <= '0;
        end else begin
            if (evt_i) begin
                freq_q <= freq_i;
            end
            grant_q <= lock_req_i &&
                       (grant_q || (state_q == ST_IDLE && !pend_q && !evt_i));
            unique case (state_q)
                ST_INIT: begin
                    state_q <= ST_IDLE;
                    if (evt_i) pend_q <= 1'b1;
                end
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_MODIFY;
                        pend_q  <= 1'b0;
                    end else if (evt_i) begin
                        pend_q <= 1'b1;
                    end
                end
                ST_MODIFY: begin
                    state_q <= ST_WRITE;
                    if (evt_i) pend_q <= 1'b1;
                end
                ST_WRITE: begin
                    state_q <= ST_IDLE;
                    if (evt_i) pend_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign freq_q_o     = freq_q;
    assign lock_grant_o = grant_q;
    assign busy_o       = (state_q != ST_IDLE);
    assign ctl_o.modify = (state_q == ST_MODIFY);
    assign ctl_o.commit = (state_q == ST_WRITE) || (state_q == ST_INIT);

endmodule

// File: rtl/pixclk_decide.sv
module pixclk_decide
    import pixclk_pkg::*;
#(
    parameter int FREQ_W     = DEF_FREQ_W,
    parameter int THRESH_KHZ = DEF_THRESH_KHZ
) (
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              invert_i,
    output logic              sel_o
);

    localparam logic [31:0] THR = THRESH_KHZ;

    logic [31:0] freq_ext;

    assign freq_ext = 32'(freq_i);
    assign sel_o    = speed_select(freq_ext, THR, invert_i);

endmodule

// File: rtl/pixclk_shadow.sv
module pixclk_shadow
    import pixclk_pkg::*;
#(
    parameter int LATCH_W = DEF_LATCH_W,
    parameter int SEL_BIT = DEF_SEL_BIT
) (
    input  logic               clk,
    input  logic               rst,
    input  rmw_ctl_t           ctl_i,
    input  logic               sel_i,
    input  logic               ext_wr_i,
    input  logic [LATCH_W-1:0] ext_data_i,
    output logic [LATCH_W-1:0] latch_o,
    output logic               latch_we_o
);

    localparam logic [LATCH_W-1:0] SEL_MASK = LATCH_W'(1) << SEL_BIT;

    logic [LATCH_W-1:0] shadow_q;
    logic [LATCH_W-1:0] latch_q;
    logic               we_q;
    logic [LATCH_W-1:0] rmw_val;
    logic [LATCH_W-1:0] ext_val;

    // Read-modify-write of the select bit: clear, then OR in the new value.
    assign rmw_val = (shadow_q & ~SEL_MASK) | (sel_i ? SEL_MASK : '0);
    // External writers own every bit except the select bit.
    assign ext_val = (ext_data_i & ~SEL_MASK) | (shadow_q & SEL_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            latch_q  <= '0;
            we_q     <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (ctl_i.modify) begin
                shadow_q <= rmw_val;
            end else if (ext_wr_i) begin
                shadow_q <= ext_val;
                latch_q  <= ext_val;
                we_q     <= 1'b1;
            end
            if (ctl_i.commit) begin
                latch_q <= shadow_q;
                we_q    <= 1'b1;
            end
        end
    end

    assign latch_o    = latch_q;
    assign latch_we_o = we_q;

endmodule

// File: rtl/pixclk_switch.sv
module pixclk_switch
    import pixclk_pkg::*;
#(
    parameter int LATCH_W    = DEF_LATCH_W,
    parameter int SEL_BIT    = DEF_SEL_BIT,
    parameter int FREQ_W     = DEF_FREQ_W,
    parameter int THRESH_KHZ = DEF_THRESH_KHZ
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_evt_i,
    input  logic               reset_evt_i,
    input  logic [FREQ_W-1:0]  freq_khz_i,
    input  logic               invert_i,
    input  logic               lock_req_i,
    output logic               lock_grant_o,
    input  logic               wr_en_i,
    input  logic [LATCH_W-1:0] wr_data_i,
    output logic               busy_o,
    output logic [LATCH_W-1:0] latch_o,
    output logic               latch_we_o
);

    logic              evt;
    logic [FREQ_W-1:0] freq_q;
    logic              grant;
    logic              sel;
    rmw_ctl_t          ctl;

    assign evt = mode_evt_i || reset_evt_i;

    pixclk_seq #(.FREQ_W(FREQ_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .freq_i       (freq_khz_i),
        .lock_req_i   (lock_req_i),
        .freq_q_o     (freq_q),
        .lock_grant_o (grant),
        .busy_o       (busy_o),
        .ctl_o        (ctl)
    );

    pixclk_decide #(.FREQ_W(FREQ_W), .THRESH_KHZ(THRESH_KHZ)) u_decide (
        .freq_i   (freq_q),
        .invert_i (invert_i),
        .sel_o    (sel)
    );

    pixclk_shadow #(.LATCH_W(LATCH_W), .SEL_BIT(SEL_BIT)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .sel_i      (sel),
        .ext_wr_i   (wr_en_i && grant),
        .ext_data_i (wr_data_i),
        .latch_o    (latch_o),
        .latch_we_o (latch_we_o)
    );

    assign lock_grant_o = grant;

endmodule

// File: rtl/pixclk_sva.sv
module pixclk_sva #(
    parameter int LATCH_W = 8,
    parameter int SEL_BIT = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               mode_evt_i,
    input logic               reset_evt_i,
    input logic               wr_en_i,
    input logic               lock_grant_o,
    input logic               busy_o,
    input logic [LATCH_W-1:0] latch_o,
    input logic               latch_we_o
);

    p_grant_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(lock_grant_o && busy_o));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        ((mode_evt_i || reset_evt_i) && !busy_o && !lock_grant_o) |=> busy_o);

    p_write_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> latch_we_o);

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !latch_we_o |-> $stable(latch_o));

    p_sel_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_grant_o && wr_en_i) |=> (latch_o[SEL_BIT] == $past(latch_o[SEL_BIT])));

endmodule

bind pixclk_switch pixclk_sva #(.LATCH_W(LATCH_W), .SEL_BIT(SEL_BIT)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .mode_evt_i   (mode_evt_i),
    .reset_evt_i  (reset_evt_i),
    .wr_en_i      (wr_en_i),
    .lock_grant_o (lock_grant_o),
    .busy_o       (busy_o),
    .latch_o      (latch_o),
    .latch_we_o   (latch_we_o)
);

// File: tb/test_pixclk_switch.sv
`timescale 1ns/1ps
module test_pixclk_switch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_evt = 1'b0;
    logic       reset_evt = 1'b0;
    logic [15:0] freq = '0;
    logic       invert = 1'b0;
    logic       lock_req = 1'b0;
    logic       grant;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       busy;
    logic [7:0] latch;
    logic       latch_we;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_latch;

    always #2.5 clk = ~clk;

    pixclk_switch i_pixclk_switch (
        .clk          (clk),
        .rst          (rst),
        .mode_evt_i   (mode_evt),
        .reset_evt_i  (reset_evt),
        .freq_khz_i   (freq),
        .invert_i     (invert),
        .lock_req_i   (lock_req),
        .lock_grant_o (grant),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .busy_o       (busy),
        .latch_o      (latch),
        .latch_we_o   (latch_we)
    );

    typedef struct packed {
        logic [15:0] f;
        logic        inv;
        logic        sel;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{16'd24000, 1'b0, 1'b0},
        '{16'd25175, 1'b0, 1'b0},
        '{16'd36000, 1'b0, 1'b1},
        '{16'd29999, 1'b0, 1'b0},
        '{16'd30000, 1'b0, 1'b1},
        '{16'd0,     1'b0, 1'b0},
        '{16'd65535, 1'b0, 1'b1},
        '{16'd36000, 1'b1, 1'b0},
        '{16'd24000, 1'b1, 1'b1},
        '{16'd25175, 1'b1, 1'b1}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Drive a one-cycle strobe at a negedge and follow the update to its write.
    task automatic run_update(input logic [15:0] f, input logic use_reset_evt,
                              input logic [7:0] expv, input string req);
        freq = f;
        if (use_reset_evt) reset_evt = 1'b1; else mode_evt = 1'b1;
        @(negedge clk);
        mode_evt = 1'b0; reset_evt = 1'b0;
        chk(busy === 1'b1 && latch_we === 1'b0, "R2", {busy, latch_we}, 2'b10);
        @(negedge clk);
        chk(busy === 1'b1, "R2", busy, 1);
        @(negedge clk);
        chk(busy === 1'b0 && latch_we === 1'b1, "R2", {busy, latch_we}, 2'b01);
        chk(latch === expv, req, latch, expv);
        @(negedge clk);
        chk(latch_we === 1'b0 && latch === expv, "R9", {latch_we, latch}, {1'b0, expv});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state and single write after release
        repeat (3) @(negedge clk);
        chk(latch === 8'h00 && latch_we === 1'b0 && grant === 1'b0, "R1",
            {grant, latch_we, latch}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(latch_we === 1'b1 && latch === 8'h00, "R1", {latch_we, latch}, 9'h100);
        @(negedge clk);
        chk(latch_we === 1'b0 && busy === 1'b0, "R1", {latch_we, busy}, 0);

        // R6: granted writes update all bits but bit 5
        lock_req = 1'b1;
        @(negedge clk);
        chk(grant === 1'b1, "R7", grant, 1);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        chk(latch === 8'hDF && latch_we === 1'b1, "R6", latch, 8'hDF);
        wr_data = 8'h20;
        @(negedge clk);
        chk(latch === 8'h00, "R6", latch, 8'h00);
        wr_data = 8'h7A;
        @(negedge clk);
        chk(latch === 8'h5A, "R6", latch, 8'h5A);
        wr_en = 1'b0; lock_req = 1'b0;
        @(negedge clk);
        chk(grant === 1'b0 && latch_we === 1'b0, "R7", {grant, latch_we}, 0);

        // R10: ungranted write ignored
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        chk(latch_we === 1'b0 && latch === 8'h5A, "R10", latch, 8'h5A);
        @(negedge clk);
        chk(latch_we === 1'b0 && latch === 8'h5A, "R10", latch, 8'h5A);
        wr_en = 1'b0;

        // R3 R4 R5: vector table, alternating strobe kinds
        exp_latch = 8'h5A;
        for (int i = 0; i < 10; i++) begin
            invert = VEC[i].inv;
            exp_latch = (exp_latch & 8'hDF) | (VEC[i].sel ? 8'h20 : 8'h00);
            run_update(VEC[i].f, i[0], exp_latch, VEC[i].inv ? "R4" : "R3/R5");
        end
        invert = 1'b0;

        // R7: request during busy is not granted until idle
        mode_evt = 1'b1; freq = 16'd36000;
        @(negedge clk);
        mode_evt = 1'b0; lock_req = 1'b1;
        chk(grant === 1'b0, "R7", grant, 0);
        @(negedge clk);
        chk(grant === 1'b0, "R7", grant, 0);
        @(negedge clk);
        chk(grant === 1'b0 && latch === 8'h7A && latch_we === 1'b1, "R7",
            {grant, latch}, 9'h07A);
        @(negedge clk);
        chk(grant === 1'b1, "R7", grant, 1);

        // R8: strobe during grant deferred until release
        freq = 16'd24000; mode_evt = 1'b1;
        @(negedge clk);
        mode_evt = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(busy === 1'b0 && latch === 8'h7A && latch_we === 1'b0, "R8",
                {busy, latch_we, latch}, 10'h07A);
            @(negedge clk);
        end
        lock_req = 1'b0;
        @(negedge clk);
        chk(grant === 1'b0 && busy === 1'b0, "R8", {grant, busy}, 0);
        @(negedge clk);
        chk(busy === 1'b1, "R8", busy, 1);
        @(negedge clk);
        @(negedge clk);
        chk(latch_we === 1'b1 && latch === 8'h5A, "R8", {latch_we, latch}, 9'h15A);

        summary();
    end

endmodule